// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block identifies which half of an interlaced frame each vertical sync pulse opens. The vertical drive input arrives asynchronously, so it first passes through a synchroniser clocked by the line-locked double-rate horizontal clock. The bench supplies that clock and the horizontal blanking window, in place of the line divider that would drive them on the chip.

A configuration input chooses which edge of the resynchronised vertical pulse counts as the reference. The block looks at the blanking window in the cycle where that edge is seen. If the window is open in that cycle, the pulse opens field one. If it is closed, the pulse opens field two. The same edge also marks the start of the vertical scan.

The outputs are:
- a field flag, which holds its value from one reference edge to the next;
- a one-cycle field-start strobe for the vertical scan;
- a sticky bit that records that at least one reference edge has been seen since reset.

Top module: `field_parity_detector`

## Requirements
- R1: While reset is asserted and after it is released, the field flag reads 0 (field one), the strobe is 0 and the sticky bit is 0. This holds until the first reference edge.
- R2: With `lead_edge_sel` = 1, the rising edge of `vdrive_in` is the reference. A rise first sampled at clock edge n raises `field_start` in the cycle that follows clock edge n+3 (two synchroniser stages).
- R3: With `lead_edge_sel` = 0, the falling edge of `vdrive_in` is the reference. A fall first sampled at clock edge n raises `field_start` in the cycle that follows clock edge n+3.
- R4: For a fall or rise sampled at edge n, `hblank_in` is evaluated at clock edge n+2. At the strobe, `field_is_second` becomes 0 if `hblank_in` was 1 at that edge and 1 if it was 0. The value of `hblank_in` in every other cycle has no effect.
- R5: `field_start` is high for exactly one cycle per reference edge. The non-selected edge of the pulse gives no strobe and leaves the field flag unchanged.
- R6: `field_is_second` changes only in the cycle in which `field_start` is high.
- R7: `edge_seen` becomes 1 together with the first strobe after reset. It then stays 1 until reset.
- R8: A vertical pulse only one clock long still yields exactly one strobe, in either edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2h | input | 1 | Line-locked double-rate horizontal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vdrive_in | input | 1 | Asynchronous vertical drive pulse |
| hblank_in | input | 1 | Horizontal blanking window, aligned to clk_2h |
| lead_edge_sel | input | 1 | 1: rising edge is the reference, 0: falling edge |
| field_is_second | output | 1 | 0 = field one, 1 = field two |
| field_start | output | 1 | One-cycle strobe on each reference edge |
| edge_seen | output | 1 | Sticky: a reference edge has been seen since reset |

## Verification
Pulses are sent in both edge modes against four blanking patterns:
- window never open;
- window always open;
- window open only in the compare cycle;
- window open in every cycle except the compare cycle.

The last two patterns show whether the window is sampled in exactly the right cycle; a design that samples one cycle early or late fails them. Wide and one-clock pulses check that only the selected edge produces a strobe. A mid-run reset checks that the flag, the strobe and the sticky bit all return to their idle values.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  typedef enum logic {
    FIELD_ONE = 1'b0,
    FIELD_TWO = 1'b1
  } field_id_e;

  // Reference edge test: rise when lead is selected, fall otherwise.
  function automatic logic pick_edge(input logic cur, input logic prev, input logic lead);
    return lead ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Blanking window open at the compare edge means field one.
  function automatic field_id_e field_from_window(input logic in_win);
    return in_win ? FIELD_ONE : FIELD_TWO;
  endfunction

endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/fpd_edge_pick.sv
module fpd_edge_pick
  import fpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic hblank,
  input  logic lead_sel,
  output logic edge_now,
  output logic evt_valid,
  output logic evt_inwin
);
  logic prev_q;

  assign edge_now = pick_edge(vsync, prev_q, lead_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      evt_valid <= 1'b0;
      evt_inwin <= 1'b0;
    end else begin
      prev_q    <= vsync;
      evt_valid <= edge_now;
      evt_inwin <= edge_now & hblank;
    end
  end
endmodule

// File: rtl/fpd_field_track.sv
module fpd_field_track
  import fpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  logic evt_inwin,
  output logic strobe,
  output logic is_second,
  output logic seen
);
  field_id_e field_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= FIELD_ONE;
      strobe  <= 1'b0;
      seen    <= 1'b0;
    end else begin
      strobe <= evt_valid;
      if (evt_valid) begin
        field_q <= field_from_window(evt_inwin);
        seen    <= 1'b1;
      end
    end
  end

  assign is_second = (field_q == FIELD_TWO);
endmodule

// File: rtl/field_parity_detector.sv
module field_parity_detector #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_2h,
  input  logic rst_n,
  input  logic vdrive_in,
  input  logic hblank_in,
  input  logic lead_edge_sel,
  output logic field_is_second,
  output logic field_start,
  output logic edge_seen
);
  logic vsync;
  logic edge_now;
  logic evt_valid;
  logic evt_inwin;

  fpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_2h),
    .rst_n (rst_n),
    .d     (vdrive_in),
    .q     (vsync)
  );

  fpd_edge_pick u_pick (
    .clk       (clk_2h),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .hblank    (hblank_in),
    .lead_sel  (lead_edge_sel),
    .edge_now  (edge_now),
    .evt_valid (evt_valid),
    .evt_inwin (evt_inwin)
  );

  fpd_field_track u_track (
    .clk       (clk_2h),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_inwin (evt_inwin),
    .strobe    (field_start),
    .is_second (field_is_second),
    .seen      (edge_seen)
  );
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
  input logic clk,
  input logic rst_n,
  input logic edge_now,
  input logic hblank,
  input logic field_start,
  input logic field_flag,
  input logic seen
);
  // R5
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);

  // R2
  strobe_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> $past(edge_now, 2));

  // R4
  parity_from_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> (field_flag == !$past(hblank, 2)));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |-> $stable(field_flag));

  // R7
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> seen);

  // R7
  seen_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> seen);
endmodule

bind field_parity_detector fpd_checker u_fpd_checker (
  .clk         (clk_2h),
  .rst_n       (rst_n),
  .edge_now    (edge_now),
  .hblank      (hblank_in),
  .field_start (field_start),
  .field_flag  (field_is_second),
  .seen        (edge_seen)
);

// File: tb/test_field_parity_detector.sv
`timescale 1ns/1ps
module test_field_parity_detector;
  localparam real CLK_P = 8.0;

  logic clk_2h = 1'b0;
  logic rst_n = 1'b0;
  logic vdrive_in = 1'b0;
  logic hblank_in = 1'b0;
  logic lead_edge_sel = 1'b1;
  logic field_is_second;
  logic field_start;
  logic edge_seen;

  int n_tests = 0;
  int n_fail = 0;
  logic exp_flag = 1'b0;
  logic exp_seen = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_2h = ~clk_2h;

  field_parity_detector i_field_parity_detector (
    .clk_2h          (clk_2h),
    .rst_n           (rst_n),
    .vdrive_in       (vdrive_in),
    .hblank_in       (hblank_in),
    .lead_edge_sel   (lead_edge_sel),
    .field_is_second (field_is_second),
    .field_start     (field_start),
    .edge_seen       (edge_seen)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Window modes: 0 never open, 1 only at compare edge, 2 all but compare edge, 3 always open.
  task automatic run_pulse(input logic lead, input int width, input int win_mode, input string req);
    int c;
    int strobes;
    logic new_flag;
    lead_edge_sel = lead;
    c = lead ? 3 : width + 3;
    new_flag = (win_mode == 1 || win_mode == 3) ? 1'b0 : 1'b1;
    strobes = 0;
    for (int k = 1; k <= width + 7; k++) begin
      vdrive_in = (k <= width);
      case (win_mode)
        0: hblank_in = 1'b0;
        1: hblank_in = (k == c);
        2: hblank_in = (k != c);
        default: hblank_in = 1'b1;
      endcase
      @(posedge clk_2h);
      @(negedge clk_2h);
      if (k == c + 1) begin
        exp_flag = new_flag;
        exp_seen = 1'b1;
      end
      if (field_start) strobes++;
      check(req, $sformatf("strobe k=%0d", k), field_start, (k == c + 1));
      check("R6", $sformatf("flag k=%0d", k), field_is_second, exp_flag);
      check("R7", $sformatf("seen k=%0d", k), edge_seen, exp_seen);
    end
    check("R5", "one strobe per pulse", (strobes == 1), 1'b1);
    hblank_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vdrive_in = 1'b0;
    repeat (3) @(negedge clk_2h);
    check("R1", "flag in reset", field_is_second, 1'b0);
    check("R1", "strobe in reset", field_start, 1'b0);
    check("R1", "seen in reset", edge_seen, 1'b0);
    rst_n = 1'b1;
    exp_flag = 1'b0;
    exp_seen = 1'b0;
    repeat (4) begin
      @(negedge clk_2h);
      check("R1", "flag after reset", field_is_second, 1'b0);
      check("R1", "strobe after reset", field_start, 1'b0);
    end
  endtask

  task automatic t_reset();         do_reset();                 endtask
  task automatic t_lead_modes();    run_pulse(1'b1, 5, 0, "R2"); run_pulse(1'b1, 5, 3, "R2"); endtask
  task automatic t_trail_modes();   run_pulse(1'b0, 6, 0, "R3"); run_pulse(1'b0, 4, 3, "R3"); endtask
  task automatic t_window_timing(); run_pulse(1'b1, 4, 1, "R4"); run_pulse(1'b1, 4, 2, "R4");
                                    run_pulse(1'b0, 5, 2, "R4"); run_pulse(1'b0, 5, 1, "R4"); endtask
  task automatic t_short_pulse();   run_pulse(1'b1, 1, 0, "R8"); run_pulse(1'b0, 1, 3, "R8"); endtask
  task automatic t_sticky_reset();  run_pulse(1'b1, 3, 2, "R7"); do_reset();
                                    run_pulse(1'b0, 3, 0, "R7"); endtask

  initial begin
    @(negedge clk_2h);
    t_reset();
    t_lead_modes();
    t_trail_modes();
    t_window_timing();
    t_short_pulse();
    t_sticky_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_2h);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule